// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the configuration front end of a legacy-style eight-input interrupt controller. Software reaches it through a byte-wide port with one address bit. A write to port 0 with the select bit set opens a multi-step setup sequence. The port-1 writes that follow are taken, in a fixed order, as the vector base, the cascade setting and, if that step was requested, the mode word. Once the sequence is finished, port-1 writes load the interrupt mask.

The block presents the live mask, the vector base, the cascade map or slave identity, the mode bits and a flag that says whether setup is complete. Two instances form a master/slave pair. A strap pin selects how each instance reads its cascade byte. The two mask read-backs combine into a 16-bit mask, with the slave's byte in the upper half.

Priority resolution, acknowledge cycles, in-service tracking and end-of-interrupt commands belong to other blocks. This block only sets the reset values of the priority-related mode bits.

Top module: `pic_prog_top`

## Requirements
- R1: A synchronous reset sets the state to uninitialized. It drives `irq_mask` to 8'hFF and `initialized` to 0, clears the vector, cascade map and `cpu_mode`, and sets `slave_id` and `lowest_prio` to 7.
- R2: A write to port 0 (`addr`=0) with bit 4 set is a start command. It begins a new sequence from any state. In the next cycle `irq_mask` reads 8'h00 and `initialized` reads 0.
- R3: A start command sets `lowest_prio` to 7 and `slave_id` to 7. It clears `special_mask` and `cpu_mode`.
- R4: The first port-1 write after a start command is the vector byte. `vector_base` shows its bits 7:3, and bits 2:0 of `vector_base` are always 0.
- R5: The next port-1 write is the cascade byte. With `slave_strap`=0 it loads all eight bits into `cascade_map`. With `slave_strap`=1 bits 2:0 load `slave_id` and `cascade_map` keeps its value.
- R6: When bit 1 of the start command is set (single mode), the cascade step is skipped.
- R7: When bit 0 of the start command is set, one more port-1 write is taken as the mode byte, and its bit 0 drives `cpu_mode`. When bit 0 is clear, `cpu_mode` stays 0 and the sequence ends after the vector or cascade step.
- R8: `initialized` rises in the cycle after the final step of the sequence is taken. After that, every port-1 write loads `irq_mask` (1 = input masked).
- R9: `rd_data` equals `irq_mask` while `addr`=1 and 8'h00 while `addr`=0, with no latency.
- R10: A port-0 write with bit 4 clear changes no output.
- R11: Before a start command has been seen, port-1 writes leave `irq_mask`, `vector_base` and `initialized` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_strap | input | 1 | 1: instance is a slave, 0: master |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | Port select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (mask on port 1) |
| irq_mask | output | 8 | Interrupt mask, 1 = masked |
| vector_base | output | 8 | Vector base, low 3 bits zero |
| cascade_map | output | 8 | Inputs with slaves attached (master) |
| slave_id | output | 3 | Slave identity |
| lowest_prio | output | 3 | Input holding lowest priority |
| special_mask | output | 1 | Special mask mode flag |
| cpu_mode | output | 1 | Microprocessor mode bit |
| initialized | output | 1 | Setup sequence complete |

## Verification
A wrong sequence step shows up as a misrouted byte on the cycle after the write. A mask value can appear in `vector_base` or `cascade_map`, or a config byte can appear in `irq_mask`. The failure can also take the form of `initialized` rising one write early or late. Because the bench model runs alongside the design and every output is compared on every cycle, such a fault is reported within one clock of the write that exposes it. A wrong skip decision is exercised by the single-mode, no-mode-byte and restart-mid-sequence scenarios. A wrong strap decision is exercised by running the cascade step once with `slave_strap`=0 and once with `slave_strap`=1.

// File: rtl/pic_prog_pkg.sv
package pic_prog_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_VEC    = 3'd1,
    ST_CASC   = 3'd2,
    ST_MODE   = 3'd3,
    ST_READY  = 3'd4
  } step_e;

  localparam int START_BIT  = 4;
  localparam int SINGLE_BIT = 1;
  localparam int MODEREQ_BIT = 0;
  localparam int CPU_BIT    = 0;

  // step following the vector byte
  function automatic step_e after_vector(input logic single, input logic mode_req);
    if (!single)       return ST_CASC;
    else if (mode_req) return ST_MODE;
    else               return ST_READY;
  endfunction

  // step following the cascade byte
  function automatic step_e after_cascade(input logic mode_req);
    return mode_req ? ST_MODE : ST_READY;
  endfunction

endpackage

// File: rtl/pic_seq_ctrl.sv
module pic_seq_ctrl
  import pic_prog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic addr,
  input  logic cmd_start,
  input  logic cmd_single,
  input  logic cmd_mode_req,
  output logic start_hit,
  output logic take_vec,
  output logic take_casc,
  output logic take_mode,
  output logic take_mask,
  output logic initialized
);

  step_e step_q, step_d;
  logic  single_q, mode_req_q;
  logic  p1_wr;

  always_comb begin
    p1_wr     = wr_en && addr;
    start_hit = wr_en && !addr && cmd_start;
    take_vec  = p1_wr && (step_q == ST_VEC);
    take_casc = p1_wr && (step_q == ST_CASC);
    take_mode = p1_wr && (step_q == ST_MODE);
    take_mask = p1_wr && (step_q == ST_READY);
  end

  always_comb begin
    step_d = step_q;
    if (start_hit)      step_d = ST_VEC;
    else if (take_vec)  step_d = after_vector(single_q, mode_req_q);
    else if (take_casc) step_d = after_cascade(mode_req_q);
    else if (take_mode) step_d = ST_READY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q     <= ST_UNINIT;
      single_q   <= 1'b0;
      mode_req_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (start_hit) begin
        single_q   <= cmd_single;
        mode_req_q <= cmd_mode_req;
      end
    end
  end

  assign initialized = (step_q == ST_READY);

  // R8: at most one step strobe per write
  a_r8_one_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_vec, take_casc, take_mode, take_mask}));

  // R6: the cascade step is never reached in single mode
  a_r6_single_skips: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_CASC) |-> !single_q);

  // R7: the mode step is reached only when it was requested
  a_r7_mode_requested: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_MODE) |-> mode_req_q);

  // R8: completion follows a sequence step
  a_r8_rise_on_step: assert property (@(posedge clk) disable iff (rst)
    $rose(initialized) |-> $past(take_vec || take_casc || take_mode));

endmodule

// File: rtl/pic_cfg_bank.sv
module pic_cfg_bank
  import pic_prog_pkg::*;
#(
  parameter int N_IN = 8,
  localparam int ID_W = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slave_strap,
  input  logic            start_hit,
  input  logic            take_vec,
  input  logic            take_casc,
  input  logic            take_mode,
  input  logic [N_IN-1:0] wr_data,
  output logic [N_IN-1:0] vector_base,
  output logic [N_IN-1:0] cascade_map,
  output logic [ID_W-1:0] slave_id,
  output logic [ID_W-1:0] lowest_prio,
  output logic            special_mask,
  output logic            cpu_mode
);

  localparam logic [ID_W-1:0] TOP_IDX = ID_W'(N_IN - 1);

  logic [N_IN-1:0] vec_raw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_raw_q    <= '0;
      cascade_map  <= '0;
      slave_id     <= TOP_IDX;
      lowest_prio  <= TOP_IDX;
      special_mask <= 1'b0;
      cpu_mode     <= 1'b0;
    end else if (start_hit) begin
      slave_id     <= TOP_IDX;
      lowest_prio  <= TOP_IDX;
      special_mask <= 1'b0;
      cpu_mode     <= 1'b0;
    end else begin
      if (take_vec) vec_raw_q <= wr_data;
      if (take_casc) begin
        if (slave_strap) slave_id    <= wr_data[ID_W-1:0];
        else             cascade_map <= wr_data;
      end
      if (take_mode) cpu_mode <= wr_data[CPU_BIT];
    end
  end

  // vector base keeps only the upper bits; the input index fills the rest
  assign vector_base = {vec_raw_q[N_IN-1:ID_W], {ID_W{1'b0}}};

  // R3: start command restores the mode defaults
  a_r3_start_defaults: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> (slave_id == TOP_IDX) && (lowest_prio == TOP_IDX)
                  && !special_mask && !cpu_mode);

  // R5: a slave never alters its cascade map
  a_r5_slave_keeps_map: assert property (@(posedge clk) disable iff (rst)
    (take_casc && slave_strap) |=> $stable(cascade_map));

endmodule

// File: rtl/pic_mask_reg.sv
module pic_mask_reg #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_hit,
  input  logic            take_mask,
  input  logic [N_IN-1:0] wr_data,
  output logic [N_IN-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '1;
    else if (start_hit) mask_q <= '0;
    else if (take_mask) mask_q <= wr_data;
  end

  // R2: start command opens every input
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> (mask_q == '0));

endmodule

// File: rtl/pic_prog_top.sv
module pic_prog_top
  import pic_prog_pkg::*;
#(
  parameter int N_IN = 8,
  localparam int ID_W = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slave_strap,
  input  logic            wr_en,
  input  logic            addr,
  input  logic [N_IN-1:0] wr_data,
  output logic [N_IN-1:0] rd_data,
  output logic [N_IN-1:0] irq_mask,
  output logic [N_IN-1:0] vector_base,
  output logic [N_IN-1:0] cascade_map,
  output logic [ID_W-1:0] slave_id,
  output logic [ID_W-1:0] lowest_prio,
  output logic            special_mask,
  output logic            cpu_mode,
  output logic            initialized
);

  logic start_hit, take_vec, take_casc, take_mode, take_mask;

  pic_seq_ctrl u_seq (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .cmd_start    (wr_data[START_BIT]),
    .cmd_single   (wr_data[SINGLE_BIT]),
    .cmd_mode_req (wr_data[MODEREQ_BIT]),
    .start_hit    (start_hit),
    .take_vec     (take_vec),
    .take_casc    (take_casc),
    .take_mode    (take_mode),
    .take_mask    (take_mask),
    .initialized  (initialized)
  );

  pic_cfg_bank #(.N_IN(N_IN)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .slave_strap  (slave_strap),
    .start_hit    (start_hit),
    .take_vec     (take_vec),
    .take_casc    (take_casc),
    .take_mode    (take_mode),
    .wr_data      (wr_data),
    .vector_base  (vector_base),
    .cascade_map  (cascade_map),
    .slave_id     (slave_id),
    .lowest_prio  (lowest_prio),
    .special_mask (special_mask),
    .cpu_mode     (cpu_mode)
  );

  pic_mask_reg #(.N_IN(N_IN)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .start_hit (start_hit),
    .take_mask (take_mask),
    .wr_data   (wr_data),
    .mask_q    (irq_mask)
  );

  assign rd_data = addr ? irq_mask : '0;

  // R10: a non-start port-0 write leaves the outputs alone
  a_r10_port0_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && !wr_data[START_BIT])
      |=> $stable(irq_mask) && $stable(initialized) && $stable(vector_base));

  // R11: the mask cannot move before setup completes, except on a start
  a_r11_mask_locked: assert property (@(posedge clk) disable iff (rst)
    (!initialized && !start_hit) |=> $stable(irq_mask));

  // R2: a start command drops the completion flag
  a_r2_start_drops_flag: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> !initialized);

endmodule

// File: tb/tb_pic_prog_top.sv
module tb_pic_prog_top;

  logic       clk = 1'b0;
  logic       rst, slave_strap, wr_en, addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data, irq_mask, vector_base, cascade_map;
  logic [2:0] slave_id, lowest_prio;
  logic       special_mask, cpu_mode, initialized;

  int tests = 0, fails = 0, cycles = 0;
  bit cmp_en = 0, done = 0;

  always #5 clk = ~clk;

  pic_prog_top dut (
    .clk(clk), .rst(rst), .slave_strap(slave_strap), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_mask(irq_mask),
    .vector_base(vector_base), .cascade_map(cascade_map), .slave_id(slave_id),
    .lowest_prio(lowest_prio), .special_mask(special_mask),
    .cpu_mode(cpu_mode), .initialized(initialized)
  );

  // behavioural reference model: phase 0 none,1 vector,2 cascade,3 mode,4 done
  int         m_phase;
  bit         m_single, m_wantmode;
  logic [7:0] m_mask, m_vec, m_map;
  logic [2:0] m_sid, m_prio;
  logic       m_smm, m_cpu;

  always @(posedge clk) begin
    cmp_en = 1;
    if (rst) begin
      m_phase = 0; m_single = 0; m_wantmode = 0;
      m_mask = 8'hFF; m_vec = 0; m_map = 0;
      m_sid = 7; m_prio = 7; m_smm = 0; m_cpu = 0;
    end else if (wr_en) begin
      if (addr == 1'b0) begin
        if (wr_data & 8'h10) begin
          m_phase = 1; m_mask = 0; m_sid = 7; m_prio = 7; m_smm = 0; m_cpu = 0;
          m_single = (wr_data & 8'h02) != 0;
          m_wantmode = (wr_data & 8'h01) != 0;
        end
      end else begin
        case (m_phase)
          1: begin
            m_vec = wr_data & 8'hF8;
            if (!m_single) m_phase = 2;
            else m_phase = m_wantmode ? 3 : 4;
          end
          2: begin
            if (slave_strap) m_sid = wr_data % 8;
            else m_map = wr_data;
            m_phase = m_wantmode ? 3 : 4;
          end
          3: begin m_cpu = wr_data % 2; m_phase = 4; end
          4: m_mask = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R2 irq_mask", irq_mask, m_mask);
      check("R4 vector_base", vector_base, m_vec);
      check("R5 cascade_map", cascade_map, m_map);
      check("R5 slave_id", slave_id, m_sid);
      check("R3 lowest_prio", lowest_prio, m_prio);
      check("R3 special_mask", special_mask, m_smm);
      check("R7 cpu_mode", cpu_mode, m_cpu);
      check("R8 initialized", initialized, m_phase == 4);
      check("R9 rd_data", rd_data, addr ? m_mask : 0);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; slave_strap = 0; wr_en = 0; addr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    check("R1 reset mask", irq_mask, 8'hFF);
    check("R1 reset flag", initialized, 0);

    wr(1, 8'h55);                          // R11: ignored before setup
    check("R11 mask before setup", irq_mask, 8'hFF);
    check("R11 vector before setup", vector_base, 0);

    wr(0, 8'h11);                          // start, cascade, mode byte
    check("R2 mask cleared", irq_mask, 0);
    wr(1, 8'h27);
    check("R4 vector low bits", vector_base, 8'h20);
    wr(1, 8'h04);
    check("R5 master map", cascade_map, 8'h04);
    check("R7 waits for mode", initialized, 0);
    wr(1, 8'h01);
    check("R7 cpu mode", cpu_mode, 1);
    check("R8 done", initialized, 1);
    wr(1, 8'hFB);
    addr = 1; #1;
    check("R9 read mask", rd_data, 8'hFB);

    wr(0, 8'h0B);                          // R10: non-start port-0 write
    check("R10 mask kept", irq_mask, 8'hFB);
    check("R10 flag kept", initialized, 1);

    wr(0, 8'h12);                          // single mode, no mode byte
    wr(1, 8'h78);
    check("R6 done after vector", initialized, 1);
    check("R7 cpu mode zero", cpu_mode, 0);
    wr(1, 8'hA5);
    check("R8 mask write", irq_mask, 8'hA5);

    slave_strap = 1;
    wr(0, 8'h11);
    wr(1, 8'h70);
    wr(1, 8'h02);
    check("R5 slave id", slave_id, 2);
    check("R5 map kept", cascade_map, 8'h04);
    wr(1, 8'h01);
    wr(1, 8'hFF);

    slave_strap = 0;
    wr(0, 8'h11);                          // restart mid-sequence
    wr(1, 8'h08);
    wr(0, 8'h10);
    check("R2 restart flag", initialized, 0);
    wr(1, 8'h28);
    wr(1, 8'h84);
    check("R7 done after cascade", initialized, 1);
    wr(1, 8'h3C);
    addr = 0; #1;
    check("R9 port0 read", rd_data, 0);
    repeat (3) @(posedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule